// File: doc/BRIEF.md
# Dual-Lane Multiply-Accumulate Engine

This block contains two multiply-accumulate lanes that run side by side. On every accepted beat, each lane picks one 16-bit half from each of its two 32-bit operand words. It treats the two halves as signed or unsigned, multiplies them, and optionally doubles the product with a single left shift. The lane then either loads the product, adds it to its accumulator, subtracts it from its accumulator, or zeroes the accumulator. Each accumulator is 40 bits wide by default, which leaves guard bits above a 32-bit result. When an update leaves the signed 40-bit range, the lane raises a sticky overflow flag. If saturation is enabled for that beat, the accumulator is also clamped to the most positive or most negative value.

Each lane presents three results: the full accumulator, a 32-bit extract and a 16-bit extract. The 32-bit extract saturates to the signed 32-bit range when saturation is on. The 16-bit extract can be rounded half-up, and it clamps when saturation is on. Operands and controls enter through a valid/ready handshake, and the results leave through a second one. A beat is accepted only when the output register is empty or is being drained in the same cycle. Results stay in place while the consumer holds off, so back-pressure passes straight to the producer. The overflow-clear pins are plain controls that act on any cycle.

Top module: `dual_mac`

## Requirements
- R1: When a beat is accepted with lane opcode 2'b00 (load), that lane's accumulator equals the product on the clock edge of acceptance. The out_valid output is high in the following cycle.
- R2: For each operand, the select bit picks the upper 16 bits of the word when it is 1 and the lower 16 bits when it is 0. With the signed bit at 1, both halves are sign-extended; with it at 0, both are zero-extended.
- R3: Opcode 2'b01 adds the product to the accumulator, and opcode 2'b10 subtracts the product from the accumulator.
- R4: Opcode 2'b11 sets the accumulator to zero.
- R5: When frac_shift is 1 on an accepted beat, the product is doubled before it is used.
- R6: An update whose exact result falls outside the signed ACC_W-bit range sets that lane's overflow flag. The flag stays set until that lane's ovf_clr bit is high at a clock edge with no new overflow on the same edge.
- R7: When an update overflows, the accumulator is clamped to 2^(ACC_W-1)-1 or -2^(ACC_W-1) if sat_en was 1 on that beat. If sat_en was 0, it keeps the low ACC_W bits (two's-complement wrap).
- R8: The 32-bit extract is the low 32 bits of the accumulator. With saturation on, it becomes 32'h7FFFFFFF or 32'h80000000 when the accumulator lies outside the signed 32-bit range.
- R9: The 16-bit extract is bits [31:16] of the accumulator. When round_en is 1, 2^15 is first added to the accumulator.
- R10: With saturation on, the 16-bit extract is 16'h7FFF or 16'h8000 when the value after any rounding lies outside the signed 32-bit range.
- R11: in_ready is high exactly when out_valid is low or out_ready is high. Without acceptance, the accumulators do not change. out_valid stays high until out_ready takes the result.
- R12: After reset, the accumulators are zero, the flags are clear and out_valid is low.
- R13: The two lanes are independent: each has its own operands, opcode, signedness, flag and flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Beat can be accepted |
| in_x | input | LANES*32 | First operand word per lane |
| in_y | input | LANES*32 | Second operand word per lane |
| x_hi | input | LANES | Take upper half of in_x |
| y_hi | input | LANES | Take upper half of in_y |
| sgn | input | LANES | Signed operands when 1 |
| op | input | LANES*2 | Lane opcode: 00 load, 01 add, 10 subtract, 11 zero |
| frac_shift | input | 1 | Double the products |
| round_en | input | 1 | Round the 16-bit extract |
| sat_en | input | 1 | Saturate accumulator and extracts |
| ovf_clr | input | LANES | Clear overflow flag per lane |
| out_valid | output | 1 | Results present |
| out_ready | input | 1 | Consumer takes results |
| acc_o | output | LANES*ACC_W | Accumulator values |
| ext16_o | output | LANES*16 | 16-bit extracts |
| ext32_o | output | LANES*32 | 32-bit extracts |
| ovf_o | output | LANES | Sticky overflow flags |

## Verification
The bench builds the block with LANES=2 and OP_W=16, and narrows ACC_W to 36. With four guard bits, a run of doubled full-scale products reaches the accumulator limit within about sixteen beats. Both the clamped and the wrapped overflow paths can therefore be checked quickly, along with the extract saturation that follows them. A sweep crosses eight corner operand values on both operands with both signedness settings and both shift settings. During the sweep, one lane loads while the other alternately adds and subtracts under rotating round and saturate controls. Further directed beats cover half selection, back-pressure and per-lane flag clearing.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    MAC_LOAD = 2'b00,
    MAC_ADD  = 2'b01,
    MAC_SUB  = 2'b10,
    MAC_ZERO = 2'b11
  } mac_op_e;
endpackage

// File: rtl/dmac_mul.sv
// Operand selection, sign handling and the 17x17 multiply of one lane.
module dmac_mul #(
  parameter int OP_W = 16
) (
  input  logic [2*OP_W-1:0]        x_word,
  input  logic [2*OP_W-1:0]        y_word,
  input  logic                     x_hi,
  input  logic                     y_hi,
  input  logic                     sgn,
  input  logic                     frac,
  output logic signed [2*OP_W+2:0] prod
);
  localparam int EXT_W  = OP_W + 1;
  localparam int FULL_W = 2 * EXT_W;

  logic [OP_W-1:0]          opx, opy;
  logic signed [EXT_W-1:0]  ex, ey;
  logic signed [FULL_W-1:0] full;

  always_comb begin
    opx  = x_hi ? x_word[2*OP_W-1:OP_W] : x_word[OP_W-1:0];
    opy  = y_hi ? y_word[2*OP_W-1:OP_W] : y_word[OP_W-1:0];
    ex   = {sgn & opx[OP_W-1], opx};
    ey   = {sgn & opy[OP_W-1], opy};
    full = ex * ey;
    prod = frac ? {full, 1'b0} : {full[FULL_W-1], full};
  end
endmodule

// File: rtl/dmac_lane.sv
// Accumulator register, overflow detection, clamp and sticky flag.
module dmac_lane
  import dmac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take,
  input  mac_op_e                  op,
  input  logic signed [2*OP_W+2:0] prod,
  input  logic                     sat,
  input  logic                     ovf_clr,
  output logic [ACC_W-1:0]         acc_q,
  output logic                     ovf_q
);
  localparam int PROD_W = 2 * OP_W + 3;
  localparam int SUM_W  = ACC_W + 2;
  localparam logic signed [SUM_W-1:0] MAXV = {3'b000, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] MINV = {3'b111, {(ACC_W-1){1'b0}}};

  logic signed [SUM_W-1:0] acc_x, prod_x, sum;
  logic                    hi_ovf, lo_ovf;
  logic [ACC_W-1:0]        acc_d;

  always_comb begin
    acc_x  = {{2{acc_q[ACC_W-1]}}, acc_q};
    prod_x = {{(SUM_W-PROD_W){prod[PROD_W-1]}}, prod};
    case (op)
      MAC_LOAD: sum = prod_x;
      MAC_ADD:  sum = acc_x + prod_x;
      MAC_SUB:  sum = acc_x - prod_x;
      default:  sum = '0;
    endcase
    hi_ovf = sum > MAXV;
    lo_ovf = sum < MINV;
    if (sat && hi_ovf)      acc_d = MAXV[ACC_W-1:0];
    else if (sat && lo_ovf) acc_d = MINV[ACC_W-1:0];
    else                    acc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (take) acc_q <= acc_d;
      ovf_q <= (ovf_q & ~ovf_clr) | (take & (hi_ovf | lo_ovf));
    end
  end
endmodule

// File: rtl/dmac_extract.sv
// Rounded / saturated narrow views of one accumulator.
module dmac_extract #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0]  acc,
  input  logic              rnd,
  input  logic              sat,
  output logic [OP_W-1:0]   ext16,
  output logic [2*OP_W-1:0] ext32
);
  localparam int WORD_W = 2 * OP_W;
  localparam int R_W    = ACC_W + 1;
  localparam logic signed [R_W-1:0] MAX32 = {{(R_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
  localparam logic signed [R_W-1:0] MIN32 = {{(R_W-WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};
  localparam logic signed [R_W-1:0] HALF  = R_W'(1) << (OP_W - 1);

  logic signed [R_W-1:0] wide, rv;

  always_comb begin
    wide = {acc[ACC_W-1], acc};
    rv   = rnd ? wide + HALF : wide;
    if (sat && rv > MAX32)      ext16 = {1'b0, {(OP_W-1){1'b1}}};
    else if (sat && rv < MIN32) ext16 = {1'b1, {(OP_W-1){1'b0}}};
    else                        ext16 = rv[WORD_W-1:OP_W];
    if (sat && wide > MAX32)      ext32 = {1'b0, {(WORD_W-1){1'b1}}};
    else if (sat && wide < MIN32) ext32 = {1'b1, {(WORD_W-1){1'b0}}};
    else                          ext32 = wide[WORD_W-1:0];
  end
endmodule

// File: rtl/dual_mac.sv
module dual_mac
  import dmac_pkg::*;
#(
  parameter int LANES = 2,
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [LANES*2*OP_W-1:0]  in_x,
  input  logic [LANES*2*OP_W-1:0]  in_y,
  input  logic [LANES-1:0]         x_hi,
  input  logic [LANES-1:0]         y_hi,
  input  logic [LANES-1:0]         sgn,
  input  logic [LANES*2-1:0]       op,
  input  logic                     frac_shift,
  input  logic                     round_en,
  input  logic                     sat_en,
  input  logic [LANES-1:0]         ovf_clr,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [LANES*ACC_W-1:0]   acc_o,
  output logic [LANES*OP_W-1:0]    ext16_o,
  output logic [LANES*2*OP_W-1:0]  ext32_o,
  output logic [LANES-1:0]         ovf_o
);
  localparam int WORD_W = 2 * OP_W;

  logic take, rnd_q, sat_q;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      rnd_q     <= 1'b0;
      sat_q     <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      rnd_q     <= round_en;
      sat_q     <= sat_en;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [WORD_W+2:0] prod;
    logic [ACC_W-1:0]         acc;

    dmac_mul #(.OP_W(OP_W)) u_mul (
      .x_word (in_x[g*WORD_W +: WORD_W]),
      .y_word (in_y[g*WORD_W +: WORD_W]),
      .x_hi   (x_hi[g]),
      .y_hi   (y_hi[g]),
      .sgn    (sgn[g]),
      .frac   (frac_shift),
      .prod   (prod)
    );

    dmac_lane #(.OP_W(OP_W), .ACC_W(ACC_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .op      (mac_op_e'(op[g*2 +: 2])),
      .prod    (prod),
      .sat     (sat_en),
      .ovf_clr (ovf_clr[g]),
      .acc_q   (acc),
      .ovf_q   (ovf_o[g])
    );

    dmac_extract #(.OP_W(OP_W), .ACC_W(ACC_W)) u_ext (
      .acc   (acc),
      .rnd   (rnd_q),
      .sat   (sat_q),
      .ext16 (ext16_o[g*OP_W +: OP_W]),
      .ext32 (ext32_o[g*WORD_W +: WORD_W])
    );

    assign acc_o[g*ACC_W +: ACC_W] = acc;
  end
endmodule

// File: rtl/dual_mac_chk.sv
module dual_mac_chk #(
  parameter int LANES = 2,
  parameter int ACC_W = 40
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [LANES*2-1:0]     op,
  input logic [LANES-1:0]       ovf_clr,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [LANES*ACC_W-1:0] acc_o,
  input logic [LANES-1:0]       ovf_o
);
  a_r1_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(acc_o)));

  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(acc_o));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o[g] && !ovf_clr[g]) |=> ovf_o[g]);

    a_r4_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && op[g*2 +: 2] == 2'b11) |=> (acc_o[g*ACC_W +: ACC_W] == '0));
  end
endmodule

bind dual_mac dual_mac_chk #(.LANES(LANES), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .op        (op),
  .ovf_clr   (ovf_clr),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .acc_o     (acc_o),
  .ovf_o     (ovf_o)
);

// File: tb/dual_mac_tb.sv
module dual_mac_tb;
  localparam int LANES = 2;
  localparam int OP_W  = 16;
  localparam int ACC_W = 36;
  localparam longint MAXA = (64'sd1 <<< (ACC_W - 1)) - 1;
  localparam longint MINA = -(64'sd1 <<< (ACC_W - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [LANES*32-1:0] in_x = '0, in_y = '0;
  logic [LANES-1:0] x_hi = '0, y_hi = '0, sgn = '0, ovf_clr = '0;
  logic [LANES*2-1:0] op = '0;
  logic frac_shift = 1'b0, round_en = 1'b0, sat_en = 1'b0;
  logic out_valid, out_ready = 1'b1;
  logic [LANES*ACC_W-1:0] acc_o;
  logic [LANES*16-1:0] ext16_o;
  logic [LANES*32-1:0] ext32_o;
  logic [LANES-1:0] ovf_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  longint macc [LANES];
  bit     mflg [LANES];
  bit     m_rnd, m_sat;

  always #4 clk = ~clk;

  dual_mac #(.LANES(LANES), .OP_W(OP_W), .ACC_W(ACC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .x_hi(x_hi), .y_hi(y_hi), .sgn(sgn), .op(op),
    .frac_shift(frac_shift), .round_en(round_en), .sat_en(sat_en),
    .ovf_clr(ovf_clr), .out_valid(out_valid), .out_ready(out_ready),
    .acc_o(acc_o), .ext16_o(ext16_o), .ext32_o(ext32_o), .ovf_o(ovf_o)
  );

  task automatic chk(string req, longint got, longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic longint opv(logic [15:0] v, bit s);
    return s ? longint'($signed(v)) : longint'(v);
  endfunction

  function automatic longint wrapv(longint v);
    longint w;
    w = v & ((64'sd1 <<< ACC_W) - 1);
    if (w > MAXA) w = w - (64'sd1 <<< ACC_W);
    return w;
  endfunction

  task automatic set_lane(int l, logic [31:0] x, logic [31:0] y, bit xh, bit yh, bit s, logic [1:0] o);
    in_x[l*32 +: 32] = x;
    in_y[l*32 +: 32] = y;
    x_hi[l] = xh;
    y_hi[l] = yh;
    sgn[l]  = s;
    op[l*2 +: 2] = o;
  endtask

  // Applies one accepted beat to the bench model, from the requirement arithmetic.
  task automatic model_beat();
    for (int l = 0; l < LANES; l++) begin
      logic [31:0] xw, yw;
      logic [15:0] xa, ya;
      longint p, s;
      bit ev;
      xw = in_x[l*32 +: 32];
      yw = in_y[l*32 +: 32];
      xa = x_hi[l] ? xw[31:16] : xw[15:0];
      ya = y_hi[l] ? yw[31:16] : yw[15:0];
      p = opv(xa, sgn[l]) * opv(ya, sgn[l]);
      if (frac_shift) p = p * 2;
      case (op[l*2 +: 2])
        2'b00:   s = p;
        2'b01:   s = macc[l] + p;
        2'b10:   s = macc[l] - p;
        default: s = 0;
      endcase
      ev = (s > MAXA) || (s < MINA);
      if (ev) macc[l] = sat_en ? ((s > MAXA) ? MAXA : MINA) : wrapv(s);
      else    macc[l] = s;
      mflg[l] = (mflg[l] & !ovf_clr[l]) | ev;
    end
    m_rnd = round_en;
    m_sat = sat_en;
  endtask

  task automatic check_all(string tag);
    chk("R1 out_valid", longint'(out_valid), 1);
    for (int l = 0; l < LANES; l++) begin
      string at;
      longint t, e16, e32;
      if (tag != "") at = tag;
      else if (frac_shift) at = "R5";
      else case (op[l*2 +: 2])
        2'b00:   at = "R1";
        2'b11:   at = "R4";
        default: at = "R3";
      endcase
      chk(at, longint'($signed(acc_o[l*ACC_W +: ACC_W])), macc[l]);
      t = macc[l] + (m_rnd ? 32768 : 0);
      if (m_sat && t > 64'sd2147483647)     e16 = 16'h7FFF;
      else if (m_sat && t < -64'sd2147483648) e16 = 16'h8000;
      else                                  e16 = (t >>> 16) & 16'hFFFF;
      chk(m_sat ? "R10" : "R9", longint'(ext16_o[l*16 +: 16]), e16);
      if (m_sat && macc[l] > 64'sd2147483647)       e32 = 32'h7FFFFFFF;
      else if (m_sat && macc[l] < -64'sd2147483648) e32 = 32'h80000000;
      else                                          e32 = macc[l] & 32'hFFFFFFFF;
      chk("R8", longint'(ext32_o[l*32 +: 32]), e32);
      chk("R6", longint'(ovf_o[l]), longint'(mflg[l]));
    end
  endtask

  task automatic fire(bit fr, bit rn, bit st, logic [1:0] clr, string tag);
    @(negedge clk);
    frac_shift = fr; round_en = rn; sat_en = st; ovf_clr = clr;
    in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    model_beat();
    @(negedge clk);
    in_valid = 1'b0;
    ovf_clr = '0;
    check_all(tag);
  endtask

  initial begin
    logic [15:0] corner [8];
    corner = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'hFFFE, 16'h0100};
    for (int l = 0; l < LANES; l++) begin macc[l] = 0; mflg[l] = 0; end
    m_rnd = 0; m_sat = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 acc", longint'(acc_o), 0);
    chk("R12 ovf", longint'(ovf_o), 0);
    chk("R12 out_valid", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready when empty", longint'(in_ready), 1);

    // R2: half selection and signedness
    set_lane(0, 32'hFFFF_0002, 32'h0003_8000, 1, 0, 1, 2'b00);
    set_lane(1, 32'hFFFF_0002, 32'h0003_8000, 1, 0, 0, 2'b00);
    fire(0, 0, 0, 2'b00, "R2");
    set_lane(0, 32'hFFFF_0002, 32'h0003_8000, 0, 1, 1, 2'b00);
    set_lane(1, 32'hFFFF_0002, 32'h0003_8000, 0, 1, 0, 2'b00);
    fire(0, 0, 0, 2'b00, "R2");

    // Sweep: lane 0 loads, lane 1 adds or subtracts (R1 R3 R5 R8 R9 R10)
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int s = 0; s < 2; s++)
          for (int f = 0; f < 2; f++) begin
            set_lane(0, {16'h0, corner[i]}, {corner[j], 16'h0}, 0, 1, s[0], 2'b00);
            set_lane(1, {corner[i], 16'h0}, {16'h0, corner[j]}, 1, 0, !s[0], j[0] ? 2'b10 : 2'b01);
            fire(f[0], i[0] ^ s[0], j[1] ^ f[0], 2'b00, "");
          end

    // R4 zero both and clear flags
    set_lane(0, 32'h7FFF, 32'h7FFF, 0, 0, 1, 2'b11);
    set_lane(1, 32'h7FFF, 32'h7FFF, 0, 0, 1, 2'b11);
    fire(0, 0, 0, 2'b11, "R4");

    // R7 saturated accumulation on lane 0, subtraction on lane 1
    set_lane(0, 32'h7FFF, 32'h7FFF, 0, 0, 1, 2'b01);
    set_lane(1, 32'h7FFF, 32'h7FFF, 0, 0, 1, 2'b10);
    for (int k = 0; k < 20; k++) fire(1, 1, 1, 2'b00, "R7");
    set_lane(0, 32'h0, 32'h0, 0, 0, 1, 2'b11);
    set_lane(1, 32'h0, 32'h0, 0, 0, 1, 2'b11);
    fire(0, 0, 0, 2'b00, "R4");
    // R7 wrapping accumulation
    set_lane(0, 32'h7FFF, 32'h7FFF, 0, 0, 1, 2'b01);
    set_lane(1, 32'h7FFF, 32'h7FFF, 0, 0, 1, 2'b10);
    for (int k = 0; k < 20; k++) fire(1, 0, 0, 2'b00, "R7");

    // R6 flags persist through a zeroing beat; R13 clear only lane 1
    set_lane(0, 32'h0, 32'h0, 0, 0, 0, 2'b11);
    set_lane(1, 32'h0, 32'h0, 0, 0, 0, 2'b11);
    fire(0, 0, 0, 2'b00, "R6");
    chk("R6 lane0 flag held", longint'(ovf_o[0]), 1);
    fire(0, 0, 0, 2'b10, "R13");
    chk("R13 lane0 flag kept", longint'(ovf_o[0]), 1);
    chk("R13 lane1 flag cleared", longint'(ovf_o[1]), 0);

    // R11 back-pressure
    set_lane(0, 32'h0003, 32'h0005, 0, 0, 0, 2'b00);
    set_lane(1, 32'h0007, 32'h0009, 0, 0, 0, 2'b00);
    fire(0, 0, 0, 2'b11, "R1");
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1;
    set_lane(0, 32'h0003, 32'h0005, 0, 0, 0, 2'b01);
    set_lane(1, 32'h0007, 32'h0009, 0, 0, 0, 2'b10);
    @(posedge clk);
    model_beat();
    @(negedge clk);
    chk("R11 out_valid after accept", longint'(out_valid), 1);
    chk("R11 ready low while stalled", longint'(in_ready), 0);
    @(negedge clk);
    chk("R11 held lane0", longint'($signed(acc_o[0 +: ACC_W])), macc[0]);
    chk("R11 held lane1", longint'($signed(acc_o[ACC_W +: ACC_W])), macc[1]);
    chk("R11 out_valid held", longint'(out_valid), 1);
    out_ready = 1'b1;
    @(posedge clk);
    model_beat();
    @(negedge clk);
    in_valid = 1'b0;
    check_all("R11");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule